// File: doc/BRIEF.md
# Controlled Bit-Serial Adder

The block adds two N-bit unsigned operands one bit pair per clock cycle. A one-cycle `go` pulse, seen while the block is idle, starts an operation. The controller spends one cycle in the loading state. In that cycle it copies both operand inputs into their own shift registers and clears the carry flip-flop. It then moves to the shifting state for N cycles. In each of those cycles the two shift registers present their lowest bit to a single one-bit full adder. The adder's carry is stored for the next bit, and each sum bit enters the top of a result register that shifts right.

After the last shift the controller returns to idle and raises `done` for one cycle. At that point `sum` holds the low N bits of A+B and `carry_out` holds the carry out of the top bit. Both keep their values while the block is idle. The controller has three named states: IDLE (waiting), LOAD (parallel load) and SHIFT (bit streaming). Its transitions are:
- IDLE→LOAD when `go` is high.
- LOAD→SHIFT always.
- SHIFT→SHIFT while shift cycles remain.
- SHIFT→IDLE on the last shift.

Reset returns the block to IDLE from any state.

Top module: `bitser_adder`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `sum`=0, `carry_out`=0 and `done`=0. Reset taken in the middle of an operation aborts it with no `done` pulse, and the block then accepts a new `go`.
- R2: `go` sampled high at a rising edge while IDLE moves the block to LOAD. The next edge moves it to SHIFT. `done` is first seen high after the (N+2)-th rising edge counted from the `go` edge, and it stays low before that. With no `go`, `done` stays low.
- R3: When `done` is high, `sum` equals (A+B) mod 2^N and `carry_out` equals bit N of A+B, for unsigned A and B.
- R4: The operand inputs are sampled only in the LOAD cycle. Changing them during SHIFT has no effect on the result.
- R5: The carry flip-flop is cleared in LOAD, so `carry_out` reads 0 in the first SHIFT cycle even if the previous result had a carry. Bits are summed LSB first.
- R6: `done` is high for exactly one cycle per operation.
- R7: `sum` and `carry_out` keep their values while IDLE. `sum` does not change until the first shift of the next operation.
- R8: A `go` pulse seen during LOAD or SHIFT is ignored. It does not restart the operation or alter its timing or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for every register in the block |
| rst_n | input | 1 | Asynchronous active-low reset to IDLE |
| go | input | 1 | Start request, taken only in IDLE |
| opnd_a | input | N | First operand, sampled in LOAD |
| opnd_b | input | N | Second operand, sampled in LOAD |
| sum | output | N | Low N bits of the sum |
| carry_out | output | 1 | Carry out of the most significant bit |
| done | output | 1 | One-cycle pulse marking a finished addition |

## Verification
The assertions assume that `go` and the operand inputs change only away from the rising edge. They also assume that reset is the only way to leave an operation early. They do not assume that operands are held during SHIFT. The bench therefore sweeps every operand pair at N=4, driving all inputs on the falling edge. On a third of the pairs it deliberately changes the operands and pulses `go` while the block is busy. This shows that such stimulus stays legal and has no effect.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SHIFT = 2'd2
    } state_t;

    typedef enum logic [1:0] {
        SEL_HOLD  = 2'd0,
        SEL_LOAD  = 2'd1,
        SEL_SHIFT = 2'd2
    } sel_t;

endpackage

// File: rtl/bsa_ctrl.sv
module bsa_ctrl
    import bsa_pkg::*;
#(
    parameter int N = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   go,
    output sel_t   sel,
    output logic   add_en,
    output logic   carry_clr,
    output logic   done,
    output state_t state
);
    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] CNT_INIT = CW'(N);
    localparam logic [CW-1:0] CNT_LAST = CW'(1);

    state_t        st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic          done_q;

    // state register, shift counter and done flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_q <= (st_q == ST_SHIFT) && (cnt_q == CNT_LAST);
            if (st_q == ST_LOAD) begin
                cnt_q <= CNT_INIT;
            end else if (st_q == ST_SHIFT) begin
                cnt_q <= cnt_q - CNT_LAST;
            end
        end
    end

    // next state and decoded controls
    always_comb begin
        st_d      = st_q;
        sel       = SEL_HOLD;
        add_en    = 1'b0;
        carry_clr = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (go) st_d = ST_LOAD;
            end
            ST_LOAD: begin
                sel       = SEL_LOAD;
                carry_clr = 1'b1;
                st_d      = ST_SHIFT;
            end
            ST_SHIFT: begin
                sel    = SEL_SHIFT;
                add_en = 1'b1;
                if (cnt_q == CNT_LAST) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    assign done  = done_q;
    assign state = st_q;

endmodule

// File: rtl/bsa_shreg.sv
module bsa_shreg
    import bsa_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  sel_t         sel,
    input  logic [N-1:0] par_in,
    output logic         ser_out
);
    logic [N-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            unique case (sel)
                SEL_LOAD:  q <= par_in;
                SEL_SHIFT: q <= q >> 1;
                default:   q <= q;
            endcase
        end
    end

    assign ser_out = q[0];

endmodule

// File: rtl/bsa_fa.sv
module bsa_fa (
    input  logic clk,
    input  logic rst_n,
    input  logic a_bit,
    input  logic b_bit,
    input  logic clr,
    input  logic en,
    output logic s_bit,
    output logic carry_q
);
    logic half;

    assign half  = a_bit ^ b_bit;
    assign s_bit = half ^ carry_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
        end else if (clr) begin
            carry_q <= 1'b0;
        end else if (en) begin
            carry_q <= (a_bit & b_bit) | (carry_q & half);
        end
    end

endmodule

// File: rtl/bsa_accum.sv
module bsa_accum #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         s_bit,
    output logic [N-1:0] res
);
    logic [N:0] merged;

    assign merged = {s_bit, res};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res <= '0;
        end else if (en) begin
            res <= merged[N:1];
        end
    end

endmodule

// File: rtl/bitser_adder.sv
module bitser_adder
    import bsa_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [N-1:0] opnd_a,
    input  logic [N-1:0] opnd_b,
    output logic [N-1:0] sum,
    output logic         carry_out,
    output logic         done
);
    localparam int NOPS = 2;

    sel_t         sel;
    logic         add_en;
    logic         carry_clr;
    state_t       fsm_state;
    logic         s_bit;
    logic [N-1:0] opnd [NOPS];
    logic         op_bit [NOPS];

    assign opnd[0] = opnd_a;
    assign opnd[1] = opnd_b;

    bsa_ctrl #(.N(N)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .sel      (sel),
        .add_en   (add_en),
        .carry_clr(carry_clr),
        .done     (done),
        .state    (fsm_state)
    );

    for (genvar gi = 0; gi < NOPS; gi++) begin : g_opnd
        bsa_shreg #(.N(N)) u_shreg (
            .clk    (clk),
            .rst_n  (rst_n),
            .sel    (sel),
            .par_in (opnd[gi]),
            .ser_out(op_bit[gi])
        );
    end

    bsa_fa u_fa (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_bit  (op_bit[0]),
        .b_bit  (op_bit[1]),
        .clr    (carry_clr),
        .en     (add_en),
        .s_bit  (s_bit),
        .carry_q(carry_out)
    );

    bsa_accum #(.N(N)) u_accum (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (add_en),
        .s_bit(s_bit),
        .res  (sum)
    );

endmodule

// File: rtl/bsa_chk.sv
module bsa_chk
    import bsa_pkg::*;
#(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         go,
    input logic         done,
    input logic [N-1:0] sum,
    input logic         carry_out,
    input state_t       state
);
    AST_GO_TO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && go) |=> (state == ST_LOAD)); // R2

    AST_DONE_FROM_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (state == ST_IDLE && $past(state) == ST_SHIFT)); // R2

    AST_LOAD_CLEARS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD) |=> (state == ST_SHIFT && !carry_out)); // R5

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> ($stable(sum) && $stable(carry_out))); // R7

    AST_BUSY_IGNORES_GO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && go) |=> (state != ST_LOAD)); // R8

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_LOAD || state == ST_SHIFT)); // R1

endmodule

bind bitser_adder bsa_chk #(.N(N)) u_bsa_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .done     (done),
    .sum      (sum),
    .carry_out(carry_out),
    .state    (fsm_state)
);

// File: tb/test_bitser_adder.sv
module test_bitser_adder;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         go;
    logic [W-1:0] a, b, sum;
    logic         cout, done;
    int           checks = 0;
    int           fails  = 0;
    logic [W-1:0] prev_sum;

    always #4 clk = ~clk;

    bitser_adder #(.N(W)) i_bitser_adder (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .opnd_a   (a),
        .opnd_b   (b),
        .sum      (sum),
        .carry_out(cout),
        .done     (done)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [W-1:0] va, input logic [W-1:0] vb, input bit disturb);
        logic [W:0] exp;
        exp = {1'b0, va} + {1'b0, vb};
        @(negedge clk);
        a  = va;
        b  = vb;
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        chk(sum == prev_sum, "R7", "sum held in LOAD", sum, prev_sum);
        for (int i = 1; i <= W + 1; i++) begin
            @(negedge clk);
            if (i == 1) begin
                chk(cout == 1'b0, "R5", "carry cleared", cout, 0);
                chk(sum == prev_sum, "R7", "sum held before first shift", sum, prev_sum);
                if (disturb) begin
                    a  = ~va;
                    b  = vb + 1'b1;
                    go = 1'b1;
                end
            end
            if (i == 2) go = 1'b0;
            if (i <= W) chk(done == 1'b0, "R2", "done early", done, 0);
            else        chk(done == 1'b1, "R2", "done at N+2", done, 1);
        end
        if (disturb) begin
            chk(sum == exp[W-1:0], "R4 R8", "sum after busy disturbance", sum, exp[W-1:0]);
            chk(cout == exp[W], "R4 R8", "carry after busy disturbance", cout, exp[W]);
        end else begin
            chk(sum == exp[W-1:0], "R3", "sum", sum, exp[W-1:0]);
            chk(cout == exp[W], "R3", "carry_out", cout, exp[W]);
        end
        @(negedge clk);
        chk(done == 1'b0, "R6", "done width", done, 0);
        chk(sum == exp[W-1:0] && cout == exp[W], "R7", "result held", {cout, sum}, exp);
        prev_sum = exp[W-1:0];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        go       = 1'b0;
        a        = '0;
        b        = '0;
        prev_sum = '0;
        repeat (3) @(negedge clk);
        chk(sum == 0 && cout == 0 && done == 0, "R1", "reset outputs", {done, cout, sum}, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(done == 1'b0, "R2", "no done without go", done, 0);
        end
        chk(sum == 0 && cout == 0, "R1", "idle after reset", {cout, sum}, 0);

        for (int ai = 0; ai < (1 << W); ai++) begin
            for (int bi = 0; bi < (1 << W); bi++) begin
                run_op(W'(ai), W'(bi), ((ai + bi) % 3) == 0);
            end
        end

        // abort by reset in the middle of shifting
        @(negedge clk);
        a  = W'(9);
        b  = W'(7);
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(sum == 0 && cout == 0 && done == 0, "R1", "mid-op reset", {done, cout, sum}, 0);
        rst_n = 1'b1;
        for (int i = 0; i < W + 3; i++) begin
            @(negedge clk);
            chk(done == 1'b0, "R1", "no done after abort", done, 0);
        end
        prev_sum = '0;
        run_op(W'(15), W'(1), 1'b0);
        run_op(W'(6), W'(5), 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule